// File: doc/BRIEF.md
# Prescaled Compare Timer

A machine timer holding a 64-bit up-counter and a 64-bit compare value, programmed through a small 32-bit register port. A prescaler turns the clock into ticks. On every tick the counter grows by a programmable step. When the counter is at or above the compare value, an interrupt condition exists. It is seen in a status bit and, if enabled, on a single interrupt line.

The timer runs only while its active bit is set. With the bit clear, the counter and prescaler are frozen, and neither status nor interrupt can assert, whatever the other registers hold. Software may rewrite the configuration, counter, compare and enable registers while the timer runs, and the interrupt follows the new values from the next cycle.

Word registers, selected by `bus_addr[5:2]` (the two low address bits are ignored): 0 control (bit 0 = active), 1 configuration (prescaler in bits [PRE_W-1:0], step in bits [23:16]), 2 counter low, 3 counter high, 4 compare low, 5 compare high, 6 interrupt enable (bit 0), 7 interrupt status (bit 0, read-only). Reads are combinational.

Top module: `prescaled_cmp_timer`

## Requirements
- R1: After reset, every register reads 0 except compare low and compare high, which read 0xFFFFFFFF. Any address with `bus_addr[5]` set reads 0, and writes to it change nothing.
- R2: While the active bit is 0, the counter does not change except by a software write, and the prescaler does not advance.
- R3: While the active bit is 0, the status bit reads 0 and `irq_o` is low, even when the counter is at or above the compare value and the enable bit is 1.
- R4: While active, a tick occurs on every (P+1)-th active cycle, where P is the prescaler field. Each tick adds the 8-bit step field to the counter. A write to the configuration register restarts the prescaler at 0.
- R5: The counter is a full 64-bit value. A carry out of the low word propagates into the high word.
- R6: The status bit is a level, not a latch. One cycle after a cycle in which the timer is active and the counter is at or above the compare value, it reads 1. Otherwise it reads 0, including after the counter is rewritten below the compare value.
- R7: `irq_o` is high exactly when the status bit and the enable bit are both 1. Clearing the enable bit drops `irq_o` in the cycle after the write.
- R8: A software write to a counter word takes precedence over a tick in the same cycle. If the counter is rewritten below the compare value before it gets there, no interrupt is raised.
- R9: A reset asserted while the timer is running returns every register to its reset value.
- R10: A write to the status register has no effect on the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench sets PRE_W to 4, which keeps the prescaler field small. With that width, short runs give exact tick counts for a non-zero prescale as well as for a prescale of 0. The step keeps its full 8-bit width, so a step of 255 starting just below a word boundary crosses into the high word within two cycles. A compare value of 10 with unit step puts the first interrupt at a known cycle. Both the cycle before it and the cycle of it are sampled.

// File: rtl/prescaled_cmp_timer.sv
module prescaled_cmp_timer #(
  parameter int PRE_W  = 12,
  parameter int STEP_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_o
);
  localparam int STEP_LSB = 16;
  localparam int CNT_W    = 64;

  logic             active_q, en_q, stat_q;
  logic [PRE_W-1:0] pre_val_q, pre_cnt_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0] cnt_q, cmp_q;

  wire       mapped = !bus_addr[5];
  wire [2:0] idx    = bus_addr[4:2];
  wire       wen    = bus_valid && bus_write && mapped;

  wire wr_ctrl  = wen && idx == 3'd0;
  wire wr_cfg   = wen && idx == 3'd1;
  wire wr_cntl  = wen && idx == 3'd2;
  wire wr_cnth  = wen && idx == 3'd3;
  wire wr_cmpl  = wen && idx == 3'd4;
  wire wr_cmph  = wen && idx == 3'd5;
  wire wr_en    = wen && idx == 3'd6;

  wire tick    = active_q && (pre_cnt_q == pre_val_q);
  wire [CNT_W-1:0] cnt_next = cnt_q + {{(CNT_W-STEP_W){1'b0}}, step_q};
  wire hit     = cnt_q >= cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      en_q      <= 1'b0;
      pre_val_q <= '0;
      step_q    <= '0;
      cmp_q     <= '1;
    end else begin
      if (wr_ctrl) active_q <= bus_wdata[0];
      if (wr_en)   en_q     <= bus_wdata[0];
      if (wr_cfg) begin
        pre_val_q <= bus_wdata[PRE_W-1:0];
        step_q    <= bus_wdata[STEP_LSB +: STEP_W];
      end
      if (wr_cmpl) cmp_q[31:0]  <= bus_wdata;
      if (wr_cmph) cmp_q[63:32] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q <= '0;
    end else if (wr_cfg || tick) begin
      pre_cnt_q <= '0;
    end else if (active_q) begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cntl || wr_cnth) begin
      if (wr_cntl) cnt_q[31:0]  <= bus_wdata;
      if (wr_cnth) cnt_q[63:32] <= bus_wdata;
    end else if (tick) begin
      cnt_q <= cnt_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= active_q && hit;
  end

  assign irq_o = stat_q && en_q;

  always_comb begin
    bus_rdata = '0;
    if (mapped) begin
      unique case (idx)
        3'd0: bus_rdata = {31'b0, active_q};
        3'd1: begin
          bus_rdata[PRE_W-1:0]          = pre_val_q;
          bus_rdata[STEP_LSB +: STEP_W] = step_q;
        end
        3'd2: bus_rdata = cnt_q[31:0];
        3'd3: bus_rdata = cnt_q[63:32];
        3'd4: bus_rdata = cmp_q[31:0];
        3'd5: bus_rdata = cmp_q[63:32];
        3'd6: bus_rdata = {31'b0, en_q};
        default: bus_rdata = {31'b0, stat_q};
      endcase
    end
  end

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !wr_cntl && !wr_cnth) |=> $stable(cnt_q));

  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> !irq_o);

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cntl && !wr_cnth) |=> cnt_q == $past(cnt_q) + {{(CNT_W-STEP_W){1'b0}}, $past(step_q)});

  a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt_q <= pre_val_q);

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en_q);

  a_r6_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && hit && en_q && !wr_en) |=> irq_o);

  a_r8_precedence: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cntl |=> cnt_q[31:0] == $past(bus_wdata));
endmodule

// File: tb/test_prescaled_cmp_timer.sv
module test_prescaled_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  logic irq_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [5:0] A_CTRL = 6'h00, A_CFG = 6'h04, A_CNTL = 6'h08, A_CNTH = 6'h0C,
                         A_CMPL = 6'h10, A_CMPH = 6'h14, A_EN = 6'h18, A_STAT = 6'h1C,
                         A_BAD = 6'h24;

  always #2 clk = ~clk;

  prescaled_cmp_timer #(.PRE_W(4), .STEP_W(8)) i_prescaled_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq_o !== e) begin
      fails++;
      $display("FAIL %s irq_o actual=%0b expected=%0b", tag, irq_o, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always begin
    @(negedge clk);
    #1;
    if (bus_valid && !bus_write) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  always @(negedge clk) if (irq_o === 1'b1) irq_seen = 1'b1;

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset values and unmapped space
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_CFG,  32'h0, "R1 cfg");
    rd(A_CNTL, 32'h0, "R1 cnt lo");
    rd(A_CNTH, 32'h0, "R1 cnt hi");
    rd(A_CMPL, 32'hFFFF_FFFF, "R1 cmp lo");
    rd(A_CMPH, 32'hFFFF_FFFF, "R1 cmp hi");
    rd(A_EN,   32'h0, "R1 en");
    rd(A_STAT, 32'h0, "R1 stat");
    wr(A_BAD, 32'hDEAD_BEEF);
    rd(A_BAD, 32'h0, "R1 unmapped");
    chk_irq(1'b0, "R1 reset irq");

    // R3 inactive with condition true and enable set
    wr(A_CMPL, 32'h0); wr(A_CMPH, 32'h0); wr(A_EN, 32'h1);
    wr(A_CFG, {8'h0, 8'h01, 12'h0, 4'h0});
    idle(10);
    chk_irq(1'b0, "R3 inactive irq");
    rd(A_STAT, 32'h0, "R3 inactive stat");
    rd(A_CNTL, 32'h0, "R2 inactive count");
    wr(A_EN, 32'h0);
    wr(A_CMPL, 32'hFFFF_FFFF); wr(A_CMPH, 32'hFFFF_FFFF);

    // R4 prescale 3, step 5: 12 active edges -> 3 ticks
    wr(A_CFG, {8'h0, 8'h05, 12'h0, 4'h3});
    wr(A_CTRL, 32'h1);
    idle(11);
    wr(A_CTRL, 32'h0);
    rd(A_CNTL, 32'd15, "R4 prescaled count");
    idle(10);
    rd(A_CNTL, 32'd15, "R2 frozen count");

    // R5 carry into high word, prescale 0, step 255
    wr(A_CNTL, 32'hFFFF_FF00); wr(A_CNTH, 32'h0);
    wr(A_CFG, {8'h0, 8'hFF, 12'h0, 4'h0});
    wr(A_CTRL, 32'h1);
    idle(1);
    wr(A_CTRL, 32'h0);
    rd(A_CNTL, 32'h0000_00FE, "R5 low word");
    rd(A_CNTH, 32'h1, "R5 high word");

    // R6/R7 exact interrupt cycle
    wr(A_CNTL, 32'h0); wr(A_CNTH, 32'h0);
    wr(A_CMPH, 32'h0); wr(A_CMPL, 32'd10);
    wr(A_EN, 32'h1);
    wr(A_CFG, {8'h0, 8'h01, 12'h0, 4'h0});
    wr(A_CTRL, 32'h1);
    idle(10);
    chk_irq(1'b0, "R6 before compare");
    idle(1);
    chk_irq(1'b1, "R6 at compare");
    rd(A_STAT, 32'h1, "R6 stat set");
    wr(A_EN, 32'h0);
    chk_irq(1'b0, "R7 enable cleared");
    rd(A_STAT, 32'h1, "R7 stat still set");
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h1, "R10 stat write ignored");
    wr(A_CNTL, 32'h0);
    idle(1);
    rd(A_STAT, 32'h0, "R6 level clears");
    wr(A_CTRL, 32'h0);

    // R8 rewrites before expiry
    wr(A_CNTL, 32'h0); wr(A_CMPL, 32'd20); wr(A_EN, 32'h1);
    irq_seen = 1'b0;
    wr(A_CTRL, 32'h1);
    for (int k = 0; k < 3; k++) begin
      idle(15);
      wr(A_CNTL, 32'h0);
    end
    wr(A_CTRL, 32'h0);
    checks++;
    if (irq_seen !== 1'b0) begin
      fails++;
      $display("FAIL R8 irq raised actual=1 expected=0");
    end
    rd(A_CNTL, 32'd1, "R8 write beats tick");

    // R9 reset while running
    wr(A_CFG, {8'h0, 8'h03, 12'h0, 4'h2});
    wr(A_CMPL, 32'd0);
    wr(A_CTRL, 32'h1);
    idle(6);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    rd(A_CTRL, 32'h0, "R9 ctrl");
    rd(A_CFG,  32'h0, "R9 cfg");
    rd(A_CNTL, 32'h0, "R9 cnt lo");
    rd(A_CMPL, 32'hFFFF_FFFF, "R9 cmp lo");
    rd(A_EN,   32'h0, "R9 en");
    rd(A_STAT, 32'h0, "R9 stat");
    chk_irq(1'b0, "R9 irq");

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule